// File: doc/BRIEF.md
# Packet Transmit Framer with Seeded CRC16

This block assembles one outgoing radio packet at a time and hands it, symbol by symbol, to a downstream spreader over a valid/ready handshake. A start pulse captures the frame settings. The block then sends a programmable run of preamble symbols, then two start-of-packet symbols, then a length byte. After that it passes the payload bytes through from a payload source, and it can close the frame with a two-byte CRC16.

Each output symbol carries a 2-bit type tag. The spreader uses the tag to pick the code set: preamble, first marker symbol, second marker symbol, or body. The length byte, the payload and the CRC all use the body tag, so they are all sent in the same data mode. The CRC covers only the payload. It starts from either a programmable seed or zero, as selected at start time.

Top module: `pkt_tx_framer`

## Requirements
- R1: With the CRC enabled, a frame is N preamble symbols, the first marker, the second marker, the length byte, the payload bytes, the CRC low byte, then the CRC high byte. Every symbol in it is accepted exactly once.
- R2: The preamble is exactly `cfg_pre_count` symbols, each of value 0xAA with tag 0. A count of zero gives no preamble symbol.
- R3: The marker symbols are 0x3C with tag 1, followed by 0xC3 with tag 2.
- R4: The length byte carries tag 3 and equals the `cfg_len` sampled at the accepted start. It also sets how many payload bytes are sent. Changing `cfg_len`, `cfg_pre_count`, `cfg_crc_en`, `cfg_seed` or `cfg_seed_zero` during a frame has no effect on that frame.
- R5: Payload bytes pass through unchanged with tag 3. `pay_ready` is high only while a payload byte can be accepted downstream, and exactly `cfg_len` payload bytes are taken.
- R6: The CRC uses the reflected USB polynomial (0xA001). It takes bits LSB first, updates over the payload bytes only, applies no final inversion, starts from `cfg_seed`, and is sent low byte first with tag 3.
- R7: With `cfg_seed_zero` high at start, the CRC starts from zero instead of `cfg_seed`.
- R8: With `cfg_crc_en` low at start, the frame ends after the last payload byte, or after the length byte if the length is zero.
- R9: A start pulse while a frame is in progress is ignored. No second frame follows.
- R10: `busy` is low with no valid output after reset. It rises the cycle after an accepted start and falls the cycle after the last symbol of the frame is accepted. While `busy` is low, `out_valid` and `pay_ready` stay low.
- R11: A preamble, marker, length or CRC symbol offered with `out_ready` low stays valid and unchanged until it is accepted.
- R12: With length zero and the CRC enabled, the CRC bytes equal the selected seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start request pulse |
| cfg_pre_count | input | PRE_W | Number of preamble symbols |
| cfg_len | input | LEN_W | Payload byte count, also sent as the length byte |
| cfg_crc_en | input | 1 | Append the CRC16 |
| cfg_seed_zero | input | 1 | Start the CRC from zero instead of the seed |
| cfg_seed | input | 16 | Programmable CRC seed |
| pay_data | input | DW | Payload byte from the source |
| pay_valid | input | 1 | Payload byte available |
| pay_ready | output | 1 | Payload byte taken this cycle |
| out_data | output | DW | Symbol or byte to the spreader |
| out_tag | output | 2 | 0 preamble, 1 first marker, 2 second marker, 3 body |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Spreader accepts the symbol |
| busy | output | 1 | Frame in progress |

## Verification
Random frames vary the preamble count, the payload length, the CRC enable and the seed selection. Both sides of the handshake stall at random, which separates the hold behaviour from the sequencing. Directed frames cover zero preamble, zero length with and without the CRC, and a full 255-byte payload. A known nine-byte ASCII vector with an all-ones seed pins the polynomial, the bit order and the byte order of the CRC. Mid-frame start pulses and settings that change during a frame show whether anything is sampled outside the accepted start.

// File: rtl/pkt_fr_pkg.sv
package pkt_fr_pkg;

   localparam int CRC_W = 16;

   typedef enum logic [1:0] {
      TAG_PRE  = 2'd0,
      TAG_SOP1 = 2'd1,
      TAG_SOP2 = 2'd2,
      TAG_BODY = 2'd3
   } sym_tag_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SOP1,
      ST_SOP2,
      ST_LEN,
      ST_PAY,
      ST_CRC_LO,
      ST_CRC_HI
   } fr_state_t;

endpackage

// File: rtl/pkt_fr_crc.sv
module pkt_fr_crc #(
   parameter int          W    = 16,
   parameter int          DW   = 8,
   parameter logic [15:0] POLY = 16'hA001
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [W-1:0]  seed,
   input  logic          upd,
   input  logic [DW-1:0] din,
   output logic [W-1:0]  crc
);

   logic [W-1:0] crc_q;
   logic [W-1:0] chain [0:DW];

   assign chain[0] = crc_q ^ {{(W-DW){1'b0}}, din};

   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign chain[i+1] = chain[i][0] ? ((chain[i] >> 1) ^ POLY[W-1:0])
                                      : (chain[i] >> 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    crc_q <= '0;
      else if (load) crc_q <= seed;
      else if (upd)  crc_q <= chain[DW];
   end

   assign crc = crc_q;

endmodule

// File: rtl/pkt_fr_seq.sv
module pkt_fr_seq
   import pkt_fr_pkg::*;
#(
   parameter int PRE_W = 6,
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PRE_W-1:0] pre_n,
   input  logic [LEN_W-1:0] len,
   input  logic             crc_en,
   input  logic             fire,
   output logic             launch,
   output fr_state_t        state,
   output logic [LEN_W-1:0] len_q
);

   localparam int CNT_W = (PRE_W > LEN_W) ? PRE_W : LEN_W;

   logic [CNT_W-1:0] cnt;
   logic             crc_en_q;
   fr_state_t        after_body;

   assign launch     = (state == ST_IDLE) && start;
   assign after_body = crc_en_q ? ST_CRC_LO : ST_IDLE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         len_q    <= '0;
         crc_en_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               len_q    <= len;
               crc_en_q <= crc_en;
               if (pre_n != '0) begin
                  state <= ST_PRE;
                  cnt   <= CNT_W'(pre_n) - CNT_W'(1);
               end else begin
                  state <= ST_SOP1;
               end
            end
            ST_PRE: if (fire) begin
               if (cnt == '0) state <= ST_SOP1;
               else           cnt   <= cnt - CNT_W'(1);
            end
            ST_SOP1: if (fire) state <= ST_SOP2;
            ST_SOP2: if (fire) state <= ST_LEN;
            ST_LEN: if (fire) begin
               if (len_q == '0) begin
                  state <= after_body;
               end else begin
                  state <= ST_PAY;
                  cnt   <= CNT_W'(len_q) - CNT_W'(1);
               end
            end
            ST_PAY: if (fire) begin
               if (cnt == '0) state <= after_body;
               else           cnt   <= cnt - CNT_W'(1);
            end
            ST_CRC_LO: if (fire) state <= ST_CRC_HI;
            ST_CRC_HI: if (fire) state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
   import pkt_fr_pkg::*;
#(
   parameter int          PRE_W    = 6,
   parameter int          LEN_W    = 8,
   parameter int          DW       = 8,
   parameter logic [7:0]  PRE_SYM  = 8'hAA,
   parameter logic [7:0]  SOP1_SYM = 8'h3C,
   parameter logic [7:0]  SOP2_SYM = 8'hC3,
   parameter logic [15:0] CRC_POLY = 16'hA001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PRE_W-1:0] cfg_pre_count,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             cfg_crc_en,
   input  logic             cfg_seed_zero,
   input  logic [15:0]      cfg_seed,
   input  logic [DW-1:0]    pay_data,
   input  logic             pay_valid,
   output logic             pay_ready,
   output logic [DW-1:0]    out_data,
   output logic [1:0]       out_tag,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             busy
);

   if (DW * 2 != CRC_W) begin : g_bad_dw
      $error("pkt_tx_framer: DW must be half the CRC width");
   end
   if (LEN_W > DW || LEN_W < 1) begin : g_bad_len
      $error("pkt_tx_framer: LEN_W must fit in one output byte");
   end
   if (PRE_W < 1 || PRE_W > 16) begin : g_bad_pre
      $error("pkt_tx_framer: PRE_W out of range");
   end

   fr_state_t        state;
   logic             launch;
   logic             fire;
   logic [LEN_W-1:0] len_q;
   logic [CRC_W-1:0] crc;
   logic [CRC_W-1:0] seed_sel;

   assign seed_sel = cfg_seed_zero ? '0 : cfg_seed;
   assign fire     = out_valid && out_ready;

   pkt_fr_seq #(.PRE_W(PRE_W), .LEN_W(LEN_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .pre_n  (cfg_pre_count),
      .len    (cfg_len),
      .crc_en (cfg_crc_en),
      .fire   (fire),
      .launch (launch),
      .state  (state),
      .len_q  (len_q)
   );

   pkt_fr_crc #(.W(CRC_W), .DW(DW), .POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (launch),
      .seed  (seed_sel),
      .upd   (fire && (state == ST_PAY)),
      .din   (pay_data),
      .crc   (crc)
   );

   always_comb begin
      out_data  = '0;
      out_tag   = TAG_BODY;
      out_valid = 1'b1;
      pay_ready = 1'b0;
      case (state)
         ST_IDLE:   out_valid = 1'b0;
         ST_PRE:    begin out_data = DW'(PRE_SYM);  out_tag = TAG_PRE;  end
         ST_SOP1:   begin out_data = DW'(SOP1_SYM); out_tag = TAG_SOP1; end
         ST_SOP2:   begin out_data = DW'(SOP2_SYM); out_tag = TAG_SOP2; end
         ST_LEN:    out_data = DW'(len_q);
         ST_PAY: begin
            out_data  = pay_data;
            out_valid = pay_valid;
            pay_ready = out_ready;
         end
         ST_CRC_LO: out_data = crc[DW-1:0];
         ST_CRC_HI: out_data = crc[CRC_W-1:DW];
         default:   out_valid = 1'b0;
      endcase
   end

   assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pkt_tx_framer_chk.sv
module pkt_tx_framer_chk #(
   parameter int         DW       = 8,
   parameter logic [7:0] SOP1_SYM = 8'h3C
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          out_valid,
   input logic          out_ready,
   input logic [DW-1:0] out_data,
   input logic [1:0]    out_tag,
   input logic          pay_ready
);

   assert_sop_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_tag == 2'd1 |=> out_valid && out_tag == 2'd2);

   assert_sop_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_tag == 2'd1 |-> out_data == DW'(SOP1_SYM));

   assert_pay_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pay_ready |-> out_ready && out_tag == 2'd3 && busy);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !out_valid && !pay_ready);

   assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && out_tag != 2'd3
      |=> out_valid && $stable(out_data) && $stable(out_tag));

endmodule

bind pkt_tx_framer pkt_tx_framer_chk #(.DW(DW), .SOP1_SYM(SOP1_SYM)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_tag   (out_tag),
   .pay_ready (pay_ready)
);

// File: tb/pkt_tx_framer_test.sv
`timescale 1ns/1ps
module pkt_tx_framer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  cfg_pre_count = '0;
   logic [7:0]  cfg_len = '0;
   logic        cfg_crc_en = 1'b0;
   logic        cfg_seed_zero = 1'b0;
   logic [15:0] cfg_seed = '0;
   logic [7:0]  pay_data = '0;
   logic        pay_valid = 1'b0;
   logic        pay_ready;
   logic [7:0]  out_data;
   logic [1:0]  out_tag;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic        busy;

   always #2.5 clk = ~clk;

   pkt_tx_framer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_pre_count(cfg_pre_count),
      .cfg_len(cfg_len), .cfg_crc_en(cfg_crc_en), .cfg_seed_zero(cfg_seed_zero),
      .cfg_seed(cfg_seed), .pay_data(pay_data), .pay_valid(pay_valid),
      .pay_ready(pay_ready), .out_data(out_data), .out_tag(out_tag),
      .out_valid(out_valid), .out_ready(out_ready), .busy(busy)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] pay_buf [0:255];
   int exp_d [0:511];
   int exp_t [0:511];
   int got_d [0:511];
   int got_t [0:511];

   task automatic chk(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
      logic [15:0] r = c ^ {8'h00, b};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
      return r;
   endfunction

   task automatic run_frame(int pre, int len, bit crc_en, bit sz,
                            logic [15:0] seed, bit fill_rand);
      int n_exp = 0;
      int n_got = 0;
      int pidx = 0;
      int cyc = 0;
      bit hold_p = 0;
      int hd = 0;
      int ht = 0;
      logic [15:0] c;
      string lbl;
      if (fill_rand) for (int i = 0; i < 256; i++) pay_buf[i] = 8'($urandom);
      for (int i = 0; i < pre; i++) begin exp_d[n_exp] = 'hAA; exp_t[n_exp] = 0; n_exp++; end
      exp_d[n_exp] = 'h3C; exp_t[n_exp] = 1; n_exp++;
      exp_d[n_exp] = 'hC3; exp_t[n_exp] = 2; n_exp++;
      exp_d[n_exp] = len;  exp_t[n_exp] = 3; n_exp++;
      c = sz ? 16'h0000 : seed;
      for (int i = 0; i < len; i++) begin
         exp_d[n_exp] = pay_buf[i]; exp_t[n_exp] = 3; n_exp++;
         c = crc_step(c, pay_buf[i]);
      end
      if (crc_en) begin
         exp_d[n_exp] = c[7:0];  exp_t[n_exp] = 3; n_exp++;
         exp_d[n_exp] = c[15:8]; exp_t[n_exp] = 3; n_exp++;
      end
      @(negedge clk);
      cfg_pre_count = 6'(pre); cfg_len = 8'(len); cfg_crc_en = crc_en;
      cfg_seed_zero = sz; cfg_seed = seed; start = 1'b1;
      out_ready = 1'b0; pay_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      // R4: scramble settings after the accepted start
      cfg_pre_count = 6'($urandom); cfg_len = 8'($urandom);
      cfg_crc_en = 1'($urandom); cfg_seed_zero = 1'($urandom); cfg_seed = 16'($urandom);
      chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
      while (n_got < n_exp && cyc < 5000) begin
         out_ready = ($urandom % 4) != 0;
         pay_valid = ($urandom % 3) != 0;
         pay_data  = (pidx < 256) ? pay_buf[pidx] : 8'h00;
         start     = (cyc == 3);   // R9: request while a frame is running
         #1;
         if (hold_p) begin
            chk(out_valid && int'(out_data) == hd && int'(out_tag) == ht, "R11 hold",
                {out_valid, out_tag, out_data}, {1'b1, 2'(ht), 8'(hd)});
            hold_p = 0;
         end
         if (out_valid && out_ready) begin
            got_d[n_got] = out_data; got_t[n_got] = out_tag; n_got++;
         end else if (out_valid && out_tag != 2'd3) begin
            hold_p = 1; hd = out_data; ht = out_tag;
         end
         if (pay_valid && pay_ready) pidx++;
         cyc++;
         @(negedge clk);
      end
      start = 1'b0; out_ready = 1'b1; pay_valid = 1'b0;
      chk(cyc < 5000, "frame timeout", cyc, 5000);
      chk(busy == 1'b0, "R10 busy falls", int'(busy), 0);
      chk(n_got == n_exp, crc_en ? "R1 frame length" : "R8 frame length", n_got, n_exp);
      chk(pidx == len, "R5 payload count", pidx, len);
      for (int i = 0; i < n_exp && i < n_got; i++) begin
         if (i < pre)                 lbl = "R2 preamble";
         else if (i < pre + 2)        lbl = "R3 marker";
         else if (i == pre + 2)       lbl = "R4 length";
         else if (i < pre + 3 + len)  lbl = "R5 payload";
         else if (len == 0)           lbl = "R12 seed crc";
         else if (sz)                 lbl = "R7 zero seed crc";
         else                         lbl = "R6 crc";
         chk(got_d[i] == exp_d[i] && got_t[i] == exp_t[i], lbl,
             got_t[i] * 256 + got_d[i], exp_t[i] * 256 + exp_d[i]);
      end
      for (int k = 0; k < 3; k++) begin
         #1;
         chk(!out_valid && !busy, "R9 no second frame", int'(out_valid), 0);
         @(negedge clk);
      end
   endtask

   initial begin
      #1000000;
      n_bad++;
      $display("FAIL watchdog: actual expired expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      string s;
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !out_valid && !pay_ready, "R10 reset state",
          {busy, out_valid, pay_ready}, 0);
      // R6 known vector: seed FFFF over "123456789" -> 4B37, low byte first
      s = "123456789";
      for (int i = 0; i < 9; i++) pay_buf[i] = s[i];
      run_frame(2, 9, 1, 0, 16'hFFFF, 0);
      chk(got_d[14] == 'h37 && got_d[15] == 'h4B, "R6 known vector",
          got_d[15] * 256 + got_d[14], 'h4B37);
      run_frame(0, 5, 1, 0, 16'h1234, 1);       // R2 zero preamble
      run_frame(3, 0, 1, 0, 16'hBEEF, 1);       // R12 seed passthrough
      run_frame(1, 0, 1, 1, 16'hBEEF, 1);       // R12 zero seed
      run_frame(0, 0, 0, 0, 16'h0000, 1);       // R8 shortest frame
      run_frame(4, 255, 1, 0, 16'hA5A5, 1);     // full length
      run_frame(2, 7, 0, 0, 16'h0000, 1);       // R8 no CRC
      for (int f = 0; f < 40; f++)
         run_frame(int'($urandom % 8), int'($urandom % 41), 1'($urandom),
                   1'($urandom), 16'($urandom), 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule